// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block picks which of two crossing roads, north-south or east-west, shows green. Each road has one presence sensor and one green indication. A two-state synchronous machine holds the current green road and updates it on every rising clock edge, driven only by which roads have vehicles waiting.

Demand alone decides the next state. A road with a waiting vehicle takes green when the other road is empty. When both roads are occupied, green swaps to the other road on every clock. When neither road is occupied, the present green stays. The light outputs depend only on the stored state, so they change only just after a clock edge. The sensor and light pins are plain level signals with no handshake. They are sampled and driven on every cycle.

Top module: `crossing_light_ctrl`

## Requirements
- R1: With `rst` high at a rising clock edge, the state becomes north-south green, so `light_o` reads 2'b01 after that edge, whatever the sensors show.
- R2: If `sense_i` is 2'b10 at a rising edge, `light_o` reads 2'b10 after the edge. Bit 1 means a vehicle waits on east-west, and light bit 1 means east-west green.
- R3: If `sense_i` is 2'b01 at a rising edge, `light_o` reads 2'b01 after the edge. Bit 0 means a vehicle waits on north-south, and light bit 0 means north-south green.
- R4: If `sense_i` is 2'b11 at a rising edge, green moves to the other road: 2'b01 becomes 2'b10 and 2'b10 becomes 2'b01.
- R5: If `sense_i` is 2'b00 at a rising edge, `light_o` keeps the value it had before the edge.
- R6: From the first reset onward, exactly one bit of `light_o` is set. Both greens are never on together, and there is never a moment with no green.
- R7: `light_o` is a function of the stored state only. A sensor change between clock edges leaves `light_o` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset to north-south green |
| sense_i | input | 2 | Vehicle presence: bit 0 north-south, bit 1 east-west |
| light_o | output | 2 | Green indication: bit 0 north-south, bit 1 east-west |

## Verification
The assertions assume that a reset is applied before anything else. Until then the state has no defined value, so the properties that compare one state with the next would mean nothing. They also assume `sense_i` holds known 0/1 values at every rising edge. The stimulus holds reset high for the first cycles and again in the middle of the run. It changes the sensors only just after an edge, and always to known values. It walks through every sensor code from both green states, including long runs of 2'b11 and 2'b00. It also changes the sensors in the middle of a cycle to confirm the light does not respond until the next edge.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int ROADS    = 2;
  localparam int SENSE_NS = 0;
  localparam int SENSE_EW = 1;

  typedef enum logic {
    GREEN_NS = 1'b0,
    GREEN_EW = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    DEM_NONE = 2'd0,
    DEM_NS   = 2'd1,
    DEM_EW   = 2'd2,
    DEM_BOTH = 2'd3
  } demand_e;
endpackage

// File: rtl/tlc_demand_decode.sv
module tlc_demand_decode
  import tlc_pkg::*;
(
  input  logic [ROADS-1:0] sense,
  output demand_e          demand
);
  always_comb begin
    unique case ({sense[SENSE_EW], sense[SENSE_NS]})
      2'b00:   demand = DEM_NONE;
      2'b01:   demand = DEM_NS;
      2'b10:   demand = DEM_EW;
      default: demand = DEM_BOTH;
    endcase
  end
endmodule

// File: rtl/tlc_next_phase.sv
module tlc_next_phase
  import tlc_pkg::*;
(
  input  phase_e  cur,
  input  demand_e demand,
  output phase_e  nxt
);
  always_comb begin
    unique case (demand)
      DEM_NS:   nxt = GREEN_NS;
      DEM_EW:   nxt = GREEN_EW;
      DEM_BOTH: nxt = (cur == GREEN_NS) ? GREEN_EW : GREEN_NS;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/tlc_phase_reg.sv
module tlc_phase_reg
  import tlc_pkg::*;
#(
  parameter phase_e RESET_PHASE = GREEN_NS
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_e nxt,
  output phase_e cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= RESET_PHASE;
    else     cur <= nxt;
  end

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  reset_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> cur == RESET_PHASE);
endmodule

// File: rtl/tlc_light_encode.sv
module tlc_light_encode
  import tlc_pkg::*;
(
  input  phase_e           cur,
  output logic [ROADS-1:0] light
);
  for (genvar g = 0; g < ROADS; g++) begin : g_lamp
    assign light[g] = (cur == phase_e'(g));
  end
endmodule

// File: rtl/crossing_light_ctrl.sv
module crossing_light_ctrl
  import tlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ROADS-1:0] sense_i,
  output logic [ROADS-1:0] light_o
);
  demand_e demand;
  phase_e  cur_phase;
  phase_e  nxt_phase;

  tlc_demand_decode u_decode (
    .sense  (sense_i),
    .demand (demand)
  );

  tlc_next_phase u_next (
    .cur    (cur_phase),
    .demand (demand),
    .nxt    (nxt_phase)
  );

  tlc_phase_reg #(.RESET_PHASE(GREEN_NS)) u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_phase),
    .cur (cur_phase)
  );

  tlc_light_encode u_enc (
    .cur   (cur_phase),
    .light (light_o)
  );

  // R2
  ew_only_chk: assert property (@(posedge clk) disable iff (rst)
    sense_i == 2'b10 |=> light_o == 2'b10);
  // R3
  ns_only_chk: assert property (@(posedge clk) disable iff (rst)
    sense_i == 2'b01 |=> light_o == 2'b01);
  // R4
  both_swap_chk: assert property (@(posedge clk) disable iff (rst)
    sense_i == 2'b11 |=> light_o != $past(light_o));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sense_i == 2'b00 |=> $stable(light_o));
  // R6
  one_green_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(light_o) == 1);
endmodule

// File: tb/crossing_light_ctrl_tb.sv
module crossing_light_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sense_i = 2'b00;
  logic [1:0] light_o;

  int checks = 0;
  int fails  = 0;
  int model_ew = 0;   // 0: north-south green, 1: east-west green
  bit done = 0;

  always #2 clk = ~clk;

  crossing_light_ctrl u_dut (
    .clk     (clk),
    .rst     (rst),
    .sense_i (sense_i),
    .light_o (light_o)
  );

  function automatic logic [1:0] expect_light();
    return model_ew ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: light_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive inputs, update model at the edge, compare 1 ns after
  task automatic step(input logic r, input logic [1:0] s);
    string tag;
    rst = r;
    sense_i = s;
    @(posedge clk);
    if (r) begin
      model_ew = 0;
      tag = "R1";
    end else begin
      case (s)
        2'b01: begin model_ew = 0; tag = "R3"; end
        2'b10: begin model_ew = 1; tag = "R2"; end
        2'b11: begin model_ew = 1 - model_ew; tag = "R4"; end
        default: tag = "R5";
      endcase
    end
    #1;
    check(tag, light_o, expect_light());
    checks++;
    if ($countones(light_o) != 1) begin
      fails++;
      $display("FAIL R6: light_o=%b expected one-hot", light_o);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, light_o=%b expected=done", light_o);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    #1;
    step(1'b1, 2'b10);   // R1: reset wins over sensors
    step(1'b1, 2'b11);
    step(1'b0, 2'b00);   // R5 hold NS
    step(1'b0, 2'b10);   // R2
    step(1'b0, 2'b00);   // R5 hold EW
    step(1'b0, 2'b00);
    step(1'b0, 2'b10);   // R2 already EW
    step(1'b0, 2'b01);   // R3
    step(1'b0, 2'b01);
    for (int i = 0; i < 7; i++) step(1'b0, 2'b11);   // R4 alternate
    step(1'b0, 2'b00);
    // R7: change sensors mid-cycle, light must not move before the edge
    sense_i = 2'b11;
    #1;
    check("R7", light_o, expect_light());
    sense_i = model_ew ? 2'b01 : 2'b10;
    #0.5;
    check("R7", light_o, expect_light());
    step(1'b0, 2'b00);
    step(1'b0, 2'b10);
    step(1'b1, 2'b10);   // R1 reset from EW
    step(1'b0, 2'b00);
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(1'b0, lfsr[1:0]);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule